// File: doc/BRIEF.md
# Vector Widening Signed Add/Subtract Unit

This execution unit sits in a 128-bit vector datapath. It receives a 32-bit instruction word and two 128-bit source operands. From the word it decodes an element size, a half-select bit and an add/subtract selector. It takes the lower or upper 64 bits of each source and sign-extends every narrow element to twice its width. It then adds or subtracts the matching elements and packs the double-width lanes into a 128-bit destination value.

The unit has one register stage. A request presented with `inValid` high produces its result one clock later, along with `outValid` and an `illegal` flag. The three register index fields of the word are passed through so that the surrounding register-file logic can use them. The unit produces no condition flags.

Top module: `vec_widen_add`

## Requirements
- R1: Instruction bit 30 selects the operand half. A value of 0 takes bits 63:0 of both sources, and a value of 1 takes bits 127:64.
- R2: Instruction bits 23:22 give the source element width: 00 is 8-bit, 01 is 16-bit and 10 is 32-bit. Each destination lane is twice the source width. Lane e of the result comes from element e of the selected halves, with lane 0 at the least significant bits.
- R3: Source elements are signed two's complement and are sign-extended before the operation. For example, 8'h80 + 8'h80 gives 16'hFF00, and 8'h7F + 8'h01 gives 16'h0080.
- R4: Each lane holds only the low 2N bits of the exact result, with no saturation.
- R5: Instruction bit 13 = 1 selects subtraction, and each lane then holds first minus second. Bit 13 = 0 selects addition.
- R6: The word is legal only if all of the following hold: bit31=0, bit29=0, bits28:24=01110, bit21=1, bits15:14=00, bits12:10=000, and size is not 11. A request that breaks any of these sets `illegal` and forces `result` to zero.
- R7: The index fields appear on the outputs unchanged: `rdIdx` from bits 4:0, `rnIdx` from bits 9:5 and `rmIdx` from bits 20:16.
- R8: `outValid` equals `inValid` delayed by one clock. While `inValid` is low, `result`, `illegal` and the index outputs keep their values.
- R9: After reset, `outValid`, `illegal` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| outValid | output | 1 | Result strobe, one cycle after request |
| illegal | output | 1 | Request had an illegal encoding |
| result | output | 128 | Packed double-width lanes |
| rdIdx | output | 5 | Destination register index |
| rnIdx | output | 5 | First source register index |
| rmIdx | output | 5 | Second source register index |

## Verification
The assertions run on every cycle. They check that a flagged request leaves a zero result and that size 11 always raises the illegal flag. They also check the one-cycle valid timing and the index pass-through, and that the lowest byte lane of an addition on the lower half is correct. Only the bench scenarios show the full set of lane arithmetic: every size and half, subtraction, and the sign-extension corner cases such as most-negative plus most-negative and maximum-positive plus one. These are checked against a behavioural integer model.

// File: rtl/vwa_pkg.sv
package vwa_pkg;
  localparam int IDX_W = 5;

  typedef struct packed {
    logic             useUpper;
    logic             isSub;
    logic [1:0]       sizeSel;
    logic             illegal;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
  } ctrl_t;
endpackage

// File: rtl/vwa_ctrl.sv
module vwa_ctrl
  import vwa_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       strb
);
  logic fixedOk;
  logic sizeOk;

  always_comb begin
    fixedOk = (instr[31] == 1'b0) && (instr[29] == 1'b0) &&
              (instr[28:24] == 5'b01110) && (instr[21] == 1'b1) &&
              (instr[15:14] == 2'b00) && (instr[12:10] == 3'b000);
    sizeOk  = (instr[23:22] != 2'b11);
    strb.useUpper = instr[30];
    strb.isSub    = instr[13];
    strb.sizeSel  = instr[23:22];
    strb.illegal  = !(fixedOk && sizeOk);
    strb.rd       = instr[4:0];
    strb.rn       = instr[9:5];
    strb.rm       = instr[20:16];
  end
endmodule

// File: rtl/vwa_datapath.sv
module vwa_datapath
  import vwa_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int SZ_CNT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  ctrl_t             strb,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              outValid,
  output logic              illegal,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  rnIdx,
  output logic [IDX_W-1:0]  rmIdx
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] halfA, halfB;
  logic [SZ_CNT-1:0][DATA_W-1:0] sizeRes;
  logic [DATA_W-1:0] nextRes;

  assign halfA = strb.useUpper ? srcA[DATA_W-1:HALF_W] : srcA[HALF_W-1:0];
  assign halfB = strb.useUpper ? srcB[DATA_W-1:HALF_W] : srcB[HALF_W-1:0];

  for (genvar s = 0; s < SZ_CNT; s++) begin : g_sz
    localparam int ESZ   = 8 << s;
    localparam int LANES = HALF_W / ESZ;
    for (genvar e = 0; e < LANES; e++) begin : g_ln
      logic [ESZ-1:0]   eltA, eltB;
      logic [2*ESZ-1:0] extA, extB;
      assign eltA = halfA[e*ESZ +: ESZ];
      assign eltB = halfB[e*ESZ +: ESZ];
      assign extA = {{ESZ{eltA[ESZ-1]}}, eltA};
      assign extB = {{ESZ{eltB[ESZ-1]}}, eltB};
      assign sizeRes[s][e*2*ESZ +: 2*ESZ] = strb.isSub ? (extA - extB) : (extA + extB);
    end
  end

  always_comb begin
    nextRes = '0;
    if (!strb.illegal && (int'(strb.sizeSel) < SZ_CNT))
      nextRes = sizeRes[strb.sizeSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      illegal  <= 1'b0;
      result   <= '0;
      rdIdx    <= '0;
      rnIdx    <= '0;
      rmIdx    <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        illegal <= strb.illegal;
        result  <= nextRes;
        rdIdx   <= strb.rd;
        rnIdx   <= strb.rn;
        rmIdx   <= strb.rm;
      end
    end
  end

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegal) |-> (result == '0)); // R6
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result))); // R8
  AST_IDX_PASS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (rdIdx == $past(strb.rd) && rmIdx == $past(strb.rm))); // R7
  AST_LANE0_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strb.illegal && strb.sizeSel == 2'b00 && !strb.useUpper && !strb.isSub)
    |=> (result[15:0] == $past({{8{srcA[7]}}, srcA[7:0]} + {{8{srcB[7]}}, srcB[7:0]}))); // R3
endmodule

// File: rtl/vec_widen_add.sv
module vec_widen_add
  import vwa_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              outValid,
  output logic              illegal,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        rdIdx,
  output logic [4:0]        rnIdx,
  output logic [4:0]        rmIdx
);
  ctrl_t strb;

  vwa_ctrl u_ctrl (.instr(instr), .strb(strb));

  vwa_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .illegal(illegal),
    .result(result), .rdIdx(rdIdx), .rnIdx(rnIdx), .rmIdx(rmIdx)
  );

  AST_SIZE11_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[23:22] == 2'b11) |=> illegal); // R6
endmodule

// File: tb/sim_vec_widen_add.sv
module sim_vec_widen_add;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] srcA = '0, srcB = '0;
  logic         outValid, illegal;
  logic [127:0] result;
  logic [4:0]   rdIdx, rnIdx, rmIdx;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vec_widen_add u0 (.*);

  function automatic logic [31:0] mk(bit q, logic [1:0] sz, bit sub,
                                     logic [4:0] rd, logic [4:0] rn, logic [4:0] rm);
    return 32'h0E20_0000 | (32'(q) << 30) | (32'(sz) << 22) | (32'(sub) << 13)
           | (32'(rm) << 16) | (32'(rn) << 5) | 32'(rd);
  endfunction

  function automatic bit isLegal(logic [31:0] w);
    return ((w & 32'hBF20_DC00) == 32'h0E20_0000) && (w[23:22] != 2'b11);
  endfunction

  function automatic logic [127:0] refModel(logic [31:0] w, logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    int esz, base;
    longint x, y, s;
    if (!isLegal(w)) return '0;
    esz  = 8 << w[23:22];
    base = w[30] ? 64 : 0;
    for (int e = 0; e < 64 / esz; e++) begin
      x = 0; y = 0;
      for (int k = 0; k < esz; k++) begin
        x[k] = a[base + e*esz + k];
        y[k] = b[base + e*esz + k];
      end
      if (x[esz-1]) for (int k = esz; k < 64; k++) x[k] = 1'b1;
      if (y[esz-1]) for (int k = esz; k < 64; k++) y[k] = 1'b1;
      s = w[13] ? x - y : x + y;
      for (int k = 0; k < 2*esz; k++) r[e*2*esz + k] = s[k];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [31:0] w, logic [127:0] a, logic [127:0] b);
    logic [127:0] exp = refModel(w, a, b);
    @(negedge clk);
    instr = w; srcA = a; srcB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " result"}, result, exp);
    check("R8 outValid", 128'(outValid), 128'd1);
    check("R6 illegal", 128'(illegal), 128'(!isLegal(w)));
    check("R7 indices", {rdIdx, rnIdx, rmIdx}, {w[4:0], w[9:5], w[20:16]});
    srcA = ~a; instr = mk(0, 2'b00, 0, 5'd0, 5'd0, 5'd0);
    @(negedge clk);
    check("R8 idle outValid", 128'(outValid), 128'd0);
    check("R8 idle hold", result, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b;
    repeat (3) @(negedge clk);
    check("R9 reset outValid", 128'(outValid), 128'd0);
    check("R9 reset illegal", 128'(illegal), 128'd0);
    check("R9 reset result", result, '0);
    rstN = 1'b1;

    for (int sz = 0; sz < 3; sz++)
      for (int q = 0; q < 2; q++)
        for (int sub = 0; sub < 2; sub++)
          for (int n = 0; n < 4; n++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            run(sub ? "R5 R1 R2 sub" : "R1 R2 add",
                mk(q[0], sz[1:0], sub[0], 5'($urandom), 5'($urandom), 5'($urandom)), a, b);
          end

    // R3 R4 corner cases per size: most negative + most negative, max positive + 1
    run("R3 min+min 8",  mk(0, 2'b00, 0, 1, 2, 3), {16{8'h80}}, {16{8'h80}});
    run("R3 max+1 8",    mk(1, 2'b00, 0, 4, 5, 6), {16{8'h7F}}, {16{8'h01}});
    run("R3 min+min 16", mk(0, 2'b01, 0, 7, 8, 9), {8{16'h8000}}, {8{16'h8000}});
    run("R3 max+1 16",   mk(1, 2'b01, 0, 10, 11, 12), {8{16'h7FFF}}, {8{16'h0001}});
    run("R4 min+min 32", mk(0, 2'b10, 0, 13, 14, 15), {4{32'h8000_0000}}, {4{32'h8000_0000}});
    run("R4 max+1 32",   mk(1, 2'b10, 0, 16, 17, 18), {4{32'h7FFF_FFFF}}, {4{32'h0000_0001}});
    run("R5 min-max 32", mk(0, 2'b10, 1, 19, 20, 21), {4{32'h8000_0000}}, {4{32'h7FFF_FFFF}});
    run("R5 max-min 8",  mk(1, 2'b00, 1, 22, 23, 24), {16{8'h7F}}, {16{8'h80}});
    // R2 lane order: distinct byte values in each lane
    run("R2 lane order", mk(0, 2'b00, 0, 25, 26, 27),
        128'h00000000_00000000_F8F70605_04030201, 128'h0);
    // R6 illegal forms
    run("R6 size11", mk(0, 2'b11, 0, 1, 1, 1), {4{32'hDEADBEEF}}, {4{32'h12345678}});
    run("R6 bit31",  mk(0, 2'b00, 0, 2, 2, 2) | 32'h8000_0000, {4{32'h11111111}}, {4{32'h22222222}});
    run("R6 bit21",  mk(0, 2'b01, 0, 3, 3, 3) & ~32'h0020_0000, {4{32'h33333333}}, {4{32'h44444444}});
    run("R6 bit12",  mk(1, 2'b10, 0, 4, 4, 4) | 32'h0000_1000, {4{32'h55555555}}, {4{32'h66666666}});
    run("R6 bit29",  mk(1, 2'b10, 1, 5, 5, 5) | 32'h2000_0000, {4{32'h77777777}}, {4{32'h88888888}});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule